// File: doc/BRIEF.md
# Folded Linear-Phase 79-Tap FIR Filter

This block is a 79-tap FIR filter whose impulse response is forced to be symmetric. Only 40 unique coefficients are stored, named A1 to A40. Taps 1 to 39 are each mirrored onto taps 79 down to 41. A40 is the single unpaired centre tap. The sample history is folded around its centre: before each multiply, the two samples that sit the same distance from the centre are added together. The result is 40 multiplies per output instead of 79. One shared multiplier works through those 40 products serially.

A host writes coefficients through a simple indexed write port. Samples arrive as single-cycle strobes on `in_vld`, and results leave as single-cycle strobes on `out_vld`. Each result is the exact full-precision sum, with no rounding. If every coefficient is zero except A40, the filter acts as a pure delay. Pulling `en` low clears the whole sample history so that the next run starts from silence. The coefficients are kept.

A three-state sequencer controls the work:
- **ST_IDLE** waits for a sample. An accepted sample (`en` high and `in_vld` high) shifts the history and moves to **ST_FOLD**.
- **ST_FOLD** spends one cycle on each of the 40 coefficient indices. After the last index it moves to **ST_EMIT**. A drop of `en` sends it back to ST_IDLE.
- **ST_EMIT** registers the sum, pulses `out_vld`, and returns to ST_IDLE.

Top module: `fir79_fold_top`

## Requirements
- R1: After reset `out_vld` is 0, `out_dat` is 0 and every stored sample is 0. The coefficient set is A40 = 1 and all other coefficients 0, so the filter resets into bypass.
- R2: A write with `coef_we` high stores `coef_wdat` (signed) into coefficient A(`coef_addr`+1) when `coef_addr` is in the range 0 to 39. A write with `coef_addr` of 40 or more changes no coefficient.
- R3: Each result equals the sum over n = 1..79 of h(n)·x(n). Here x(1) is the newest accepted sample and x(79) the oldest. h(n) = A(n) for n ≤ 40, and h(n) = A(80−n) for n > 40.
- R4: Samples and coefficients at full scale (−32768 and 32767) give the exact result. Neither the pair sum nor the accumulation wraps.
- R5: `out_vld` is a single-cycle pulse. It is high during the clock cycle that follows the 41st rising edge after the edge that accepted the sample, and `out_dat` is valid in that cycle.
- R6: While a result is being computed (ST_FOLD or ST_EMIT), a strobe on `in_vld` is ignored. It neither enters the history nor produces a result.
- R7: While `en` is low, the history is cleared to zero, a result in progress is abandoned with no `out_vld` pulse, and `in_vld` is ignored. Coefficients keep their values.
- R8: With A40 = 1 and all other coefficients 0, each result equals the sample accepted 39 samples earlier, or 0 if fewer samples have been accepted since the history was last cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Filter enable; low clears the history |
| in_vld | input | 1 | Sample strobe |
| in_dat | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Coefficient index, 0..39 selects A1..A40 |
| coef_wdat | input | 16 | Signed coefficient value |
| out_vld | output | 1 | Result strobe |
| out_dat | output | 39 | Signed full-precision result |

## Verification
Each result is due 41 rising edges after the edge that accepted its sample: one edge to shift, 40 accumulate edges, then the edge in ST_EMIT that registers the sum and raises `out_vld`. The bench drives a sample at a falling edge. It then counts the falling edges that follow and requires the pulse to appear at falling edge 42 and at no other, so an early, late or doubled pulse counts as a failure. Stimulus that must be ignored (busy strobes, out-of-range writes, a disable during a computation) is applied inside this window. Its effect is judged from the next results, compared against a full 79-tap model built from the mirrored coefficients.

// File: rtl/fir79_pkg.sv
package fir79_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FOLD = 2'd1,
        ST_EMIT = 2'd2
    } fold_state_e;

endpackage

// File: rtl/fir79_coef_bank.sv
module fir79_coef_bank #(
    parameter int CW    = 16,
    parameter int NUNIQ = 40,
    localparam int ADRW = $clog2(NUNIQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADRW-1:0]      addr,
    input  logic signed [CW-1:0] wdat,
    output logic signed [CW-1:0] coef [NUNIQ]
);

    // Each slot is its own register; an index of NUNIQ or more matches none.
    for (genvar g = 0; g < NUNIQ; g++) begin : g_slot
        localparam logic signed [CW-1:0] RST_VAL =
            (g == NUNIQ - 1) ? CW'(1) : '0;
        logic signed [CW-1:0] slot_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= RST_VAL;
            end else if (we && (addr == ADRW'(g))) begin
                slot_q <= wdat;
            end
        end

        assign coef[g] = slot_q;
    end

    AST_BAD_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ({1'b0, addr} >= (ADRW+1)'(NUNIQ))) |=> $stable(coef[NUNIQ-1])) // R2
        else $error("out-of-range coefficient write changed the centre tap");

endmodule

// File: rtl/fir79_delay_line.sv
module fir79_delay_line #(
    parameter int DW   = 16,
    parameter int NTAP = 79
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 shift,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] taps [NTAP]
);

    for (genvar g = 0; g < NTAP; g++) begin : g_stage
        logic signed [DW-1:0] stage_q;
        logic signed [DW-1:0] stage_d;

        if (g == 0) begin : g_head
            assign stage_d = din;
        end else begin : g_body
            assign stage_d = taps[g-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                stage_q <= '0;
            end else if (shift) begin
                stage_q <= stage_d;
            end
        end

        assign taps[g] = stage_q;
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (taps[0] == '0 && taps[NTAP-1] == '0)) // R7
        else $error("history not cleared while disabled");

endmodule

// File: rtl/fir79_mac_seq.sv
module fir79_mac_seq
    import fir79_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int NTAP = 79,
    localparam int NUNIQ = (NTAP + 1) / 2,
    localparam int PW    = DW + 1,
    localparam int AW    = PW + CW + $clog2(NUNIQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] taps [NTAP],
    input  logic signed [CW-1:0] coef [NUNIQ],
    output logic                 shift,
    output logic                 out_vld,
    output logic signed [AW-1:0] out_dat
);

    localparam int IW  = $clog2(NUNIQ);
    localparam int TIW = $clog2(NTAP);
    localparam int MID = NUNIQ - 1;
    localparam logic [IW-1:0] LAST = IW'(NUNIQ - 1);

    fold_state_e state_q, state_d;
    logic [IW-1:0]          idx_q;
    logic signed [AW-1:0]   acc_q;
    logic [TIW-1:0]         lo_idx, hi_idx;
    logic signed [PW-1:0]   pre;
    logic signed [PW+CW-1:0] prod;
    logic signed [AW-1:0]   prod_ext;

    // Sample acceptance: only when idle and enabled.
    assign shift = en && in_vld && (state_q == ST_IDLE);

    // Fold: tap k pairs with tap NTAP-1-k; the centre tap stands alone.
    assign lo_idx = TIW'(idx_q);
    assign hi_idx = TIW'(NTAP - 1) - lo_idx;

    always_comb begin
        if (idx_q == LAST) begin
            pre = PW'(taps[MID]);
        end else begin
            pre = PW'(taps[lo_idx]) + PW'(taps[hi_idx]);
        end
    end

    assign prod     = pre * coef[idx_q];
    assign prod_ext = AW'(prod);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en && in_vld) state_d = ST_FOLD;
            end
            ST_FOLD: begin
                if (!en)                 state_d = ST_IDLE;
                else if (idx_q == LAST)  state_d = ST_EMIT;
            end
            ST_EMIT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            acc_q   <= '0;
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            out_vld <= 1'b0;
            if (!en) begin
                idx_q <= '0;
                acc_q <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        idx_q <= '0;
                        acc_q <= '0;
                    end
                    ST_FOLD: begin
                        acc_q <= acc_q + prod_ext;
                        idx_q <= idx_q + 1'b1;
                    end
                    ST_EMIT: begin
                        out_dat <= acc_q;
                        out_vld <= 1'b1;
                        idx_q   <= '0;
                    end
                    default: begin
                        idx_q <= '0;
                    end
                endcase
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld) // R5
        else $error("result strobe longer than one cycle");

    AST_FOLD_TO_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOLD && idx_q == LAST && en) |=> (state_q == ST_EMIT)) // R5
        else $error("fold did not end in emit");

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOLD) |-> (idx_q <= LAST)) // R3
        else $error("coefficient index beyond last unique tap");

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out_vld) // R7
        else $error("result strobe after disable");

    AST_BUSY_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOLD) |=> (state_q != ST_FOLD || $stable(taps[0]))) // R6
        else $error("history moved during fold");

endmodule

// File: rtl/fir79_fold_top.sv
module fir79_fold_top #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int NTAP = 79,
    localparam int NUNIQ = (NTAP + 1) / 2,
    localparam int ADRW  = $clog2(NUNIQ),
    localparam int OW    = DW + 1 + CW + $clog2(NUNIQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_dat,
    input  logic                 coef_we,
    input  logic [ADRW-1:0]      coef_addr,
    input  logic signed [CW-1:0] coef_wdat,
    output logic                 out_vld,
    output logic signed [OW-1:0] out_dat
);

    logic signed [DW-1:0] taps [NTAP];
    logic signed [CW-1:0] coef [NUNIQ];
    logic                 shift;

    fir79_coef_bank #(.CW(CW), .NUNIQ(NUNIQ)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .addr  (coef_addr),
        .wdat  (coef_wdat),
        .coef  (coef)
    );

    fir79_delay_line #(.DW(DW), .NTAP(NTAP)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en),
        .shift (shift),
        .din   (in_dat),
        .taps  (taps)
    );

    fir79_mac_seq #(.DW(DW), .CW(CW), .NTAP(NTAP)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .in_vld  (in_vld),
        .taps    (taps),
        .coef    (coef),
        .shift   (shift),
        .out_vld (out_vld),
        .out_dat (out_dat)
    );

    AST_SHIFT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (en && in_vld)) // R7
        else $error("sample accepted while disabled");

endmodule

// File: tb/sim_fir79_fold_top.sv
module sim_fir79_fold_top;

    localparam int NT  = 79;
    localparam int NU  = 40;
    localparam int LAT = 42;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en = 1'b0;
    logic               in_vld = 1'b0;
    logic signed [15:0] in_dat = '0;
    logic               coef_we = 1'b0;
    logic [5:0]         coef_addr = '0;
    logic signed [15:0] coef_wdat = '0;
    logic               out_vld;
    logic signed [38:0] out_dat;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    longint hist [NT];
    longint acoef [NU];
    longint xs [200];
    int     nx = 0;

    always #4 clk = ~clk;

    fir79_fold_top u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .in_vld(in_vld), .in_dat(in_dat),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdat(coef_wdat),
        .out_vld(out_vld), .out_dat(out_dat)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model();
        longint s = 0;
        for (int n = 0; n < NT; n++) begin
            s += ((n < NU) ? acoef[n] : acoef[NT - 1 - n]) * hist[n];
        end
        return s;
    endfunction

    task automatic clear_model();
        for (int n = 0; n < NT; n++) hist[n] = 0;
        nx = 0;
    endtask

    task automatic wr_coef(input int adr, input int val);
        @(negedge clk);
        coef_we = 1'b1; coef_addr = 6'(adr); coef_wdat = 16'(val);
        @(negedge clk);
        coef_we = 1'b0;
        if (adr < NU) acoef[adr] = longint'(16'(val) ^ 16'h0) - ((val & 32'h8000) != 0 ? 65536 : 0) + 0;
    endtask

    // mode 0: plain; 1: extra strobe while busy; 2: disable mid-computation
    task automatic send(input int x, input string tag, input int mode, output longint got);
        longint exp;
        int seen = 0;
        int pulses = 0;
        got = 0;
        @(negedge clk);
        in_vld = 1'b1; in_dat = 16'(x);
        for (int n = NT - 1; n > 0; n--) hist[n] = hist[n-1];
        hist[0] = x;
        xs[nx] = x; nx++;
        exp = model();
        for (int j = 1; j <= LAT + 4; j++) begin
            @(negedge clk);
            if (j == 1) in_vld = 1'b0;
            if (mode == 1 && j == 10) begin in_vld = 1'b1; in_dat = 16'(x + 1234); end
            if (mode == 1 && j == 11) in_vld = 1'b0;
            if (mode == 2 && j == 10) begin en = 1'b0; in_vld = 1'b1; end
            if (mode == 2 && j == 13) begin en = 1'b1; in_vld = 1'b0; end
            if (out_vld) begin
                pulses++;
                if (seen == 0) begin
                    seen = j;
                    got = longint'(out_dat);
                end
            end
        end
        if (mode == 2) begin
            chk(pulses == 0, "R7 abandoned result", pulses, 0);
            clear_model();
        end else begin
            chk(seen == LAT && pulses == 1, "R5 result timing", seen, LAT);
            chk(got == exp, tag, got, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; en = 1'b1;
        @(negedge clk);
        chk(out_vld == 1'b0, "R1 out_vld after reset", longint'(out_vld), 0);
        chk(out_dat == '0, "R1 out_dat after reset", longint'(out_dat), 0);
        for (int i = 0; i < NU; i++) acoef[i] = (i == NU - 1) ? 1 : 0;
        clear_model();
    endtask

    task automatic t_bypass();
        longint got;
        for (int k = 0; k < 45; k++) begin
            send(k * 731 - 15000, "R1 R3 default bypass", 0, got);
            chk(got == ((k >= 39) ? xs[k - 39] : 0), "R8 bypass delay", got,
                (k >= 39) ? xs[k - 39] : 0);
        end
    endtask

    task automatic t_bad_addr();
        longint got;
        wr_coef(40, 12345);
        wr_coef(55, -7);
        wr_coef(63, 32767);
        for (int k = 0; k < 3; k++) send(900 - k * 3001, "R2 out-of-range write ignored", 0, got);
    endtask

    task automatic t_program();
        longint got;
        for (int i = 0; i < NU; i++) wr_coef(i, ((i * 173) % 601) - 300);
        for (int k = 0; k < 50; k++) send(((k * 4099) % 20001) - 10000, "R2 R3 programmed response", 0, got);
    endtask

    task automatic t_busy();
        longint got;
        for (int k = 0; k < 4; k++) send(k * 5000 - 9000, "R6 busy strobe ignored", 1, got);
        send(321, "R6 history after busy strobes", 0, got);
    endtask

    task automatic t_disable();
        longint got;
        send(4444, "R3 before abort", 0, got);
        send(-2222, "R7", 2, got);
        send(777, "R7 coefficients kept after abort", 0, got);
        @(negedge clk);
        en = 1'b0; in_vld = 1'b1; in_dat = 16'(999);
        repeat (3) @(negedge clk);
        in_vld = 1'b0; en = 1'b1;
        chk(out_vld == 1'b0, "R7 no result while disabled", longint'(out_vld), 0);
        clear_model();
        for (int k = 0; k < 3; k++) send(100 * k + 50, "R7 cleared history, kept coefficients", 0, got);
    endtask

    task automatic t_full_scale();
        longint got;
        for (int i = 0; i < NU; i++) wr_coef(i, (i % 2 == 0) ? -32768 : 32767);
        for (int k = 0; k < 82; k++) send((k < 80) ? 32767 : -32768, "R4 full scale", 0, got);
        for (int i = 0; i < NU; i++) wr_coef(i, -32768);
        for (int k = 0; k < 80; k++) send(-32768, "R4 full scale negative", 0, got);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_bad_addr();
        t_program();
        t_busy();
        t_disable();
        t_full_scale();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                chk(1'b0, "R5 watchdog expired", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

endmodule